// File: doc/BRIEF.md
# DDR SDRAM Start-Up Command Sequencer

This block sits on the controller side of a DDR SDRAM channel and drives the clock-enable, command, bank and address pins through the start-up script the memory needs after reset. Once the script is complete, the controller's normal command path takes over. The block holds clock enable low through a stable-clock wait, then raises it with one NOP. It then issues these commands in this order: a precharge of all banks, a load of the extended mode register that enables the DLL, and a load of the mode register that also resets the DLL. A NOP-only lock window follows. After it come a second precharge of all banks, a programmable number of auto refreshes, and a final mode register load that leaves the DLL-reset bit clear.

Every wait is a parameter counted in clock cycles. Commands are always exactly the programmed spacing apart, and every cycle between two commands carries a NOP. The operating fields written into the mode register come from input ports: CAS latency code, burst type and burst length code. These inputs are read in the cycle the mode command is on the pins.

A done flag tells the rest of the controller that the memory is ready. It stays set until the next reset.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset is released, cke_o stays low for exactly T_STABLE cycles, and during those cycles the pins carry the NOP encoding (cs_n 0, ras_n 1, cas_n 1, we_n 1).
- R2: In cycle T_STABLE (counted from release), cke_o is high with a NOP on the pins. In the next cycle a precharge-all is issued (cs_n 0, ras_n 0, cas_n 1, we_n 0) with addr_o = 0x100, so bit 8 is set.
- R3: The extended mode load comes T_RP cycles after the first precharge-all. Its pins read cs_n, ras_n, cas_n and we_n all 0, ba_o = 2'b01 (bit 0 set), and addr_o = 0, so the DLL is enabled and reserved bits are zero.
- R4: The DLL-reset mode load comes T_MRD cycles after the extended load, with ba_o = 2'b00. addr_o has bit 8 = 1, bits 6:4 = cas_lat_i (3'b011 selects 3, 3'b100 selects 4), bit 3 = burst_type_i, bits 2:0 = burst_len_i, and all other bits 0.
- R5: Exactly T_LOCK NOP cycles follow the DLL-reset load. The second precharge-all, with addr_o = 0x100, comes in the next cycle.
- R6: N_REF auto refreshes follow (cs_n 0, ras_n 0, cas_n 0, we_n 1). The first comes T_RP cycles after the second precharge, and each later one comes T_RFC cycles after the previous one.
- R7: The final mode load comes T_RFC cycles after the last refresh. It has ba_o = 0 and the same fields as R4, but bit 8 is 0.
- R8: done_o rises T_MRD cycles after the final mode load and then stays high. While it is high, cke_o is high and the pins carry a NOP whatever the mode inputs do.
- R9: Every cycle after cke_o rises that carries none of the commands above carries a NOP.
- R10: Once cke_o is high, it stays high until reset.
- R11: Reset asserted at any point drives cke_o and done_o low at once. After release the script restarts from R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cas_lat_i | input | 3 | CAS latency code for mode bits 6:4 |
| burst_type_i | input | 1 | Burst order for mode bit 3 (1 interleaved) |
| burst_len_i | input | 3 | Burst length code for mode bits 2:0 |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank / mode register select |
| addr_o | output | A_W | Address / mode opcode |
| done_o | output | 1 | Start-up finished |

## Verification
The pins are decoded from one registered step, so each command appears in the cycle whose index, counted in clock edges since reset release, is the sum of the preceding spacings. The bench builds this from the parameters: cycle T_STABLE is the NOP with clock enable raised, T_STABLE+1 is the first precharge, and each later command adds T_RP, T_MRD, T_LOCK+1 or T_RFC. done is expected T_MRD cycles after the last command. The bench samples every cycle at the falling edge, one full half period after the edge that moved the step, and compares the whole pin set against that timeline. Reset is checked just after it falls, because it acts without a clock.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_WAIT,
    ST_NOP,
    ST_PRE1,
    ST_EMRS,
    ST_MRS_RST,
    ST_PRE2,
    ST_REF,
    ST_MRS_FIN,
    ST_GAP,
    ST_DONE
  } step_e;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ctl_t;

  localparam ctl_t CTL_NOP = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam ctl_t CTL_PRE = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam ctl_t CTL_MRS = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
  localparam ctl_t CTL_REF = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int              CNT_W   = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= RST_VAL;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_fsm.sv
module ddr_init_fsm
  import ddr_init_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int T_RP   = 3,
  parameter int T_MRD  = 2,
  parameter int T_RFC  = 8,
  parameter int T_LOCK = 200,
  parameter int N_REF  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output step_e            step_o
);

  localparam int REF_W = (N_REF > 1) ? $clog2(N_REF) : 1;
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(N_REF - 1);

  step_e            state_q, state_d, ret_q, ret_d, follow;
  logic [REF_W-1:0] ref_q;
  int               space;

  // spacing from this command to the next one, in cycles
  always_comb begin
    follow = state_q;
    space  = 1;
    unique case (state_q)
      ST_PRE1:    begin follow = ST_EMRS;    space = T_RP;       end
      ST_EMRS:    begin follow = ST_MRS_RST; space = T_MRD;      end
      ST_MRS_RST: begin follow = ST_PRE2;    space = T_LOCK + 1; end
      ST_PRE2:    begin follow = ST_REF;     space = T_RP;       end
      ST_REF:     begin
        follow = (ref_q == REF_LAST) ? ST_MRS_FIN : ST_REF;
        space  = T_RFC;
      end
      ST_MRS_FIN: begin follow = ST_DONE;    space = T_MRD;      end
      default:    ;
    endcase
  end

  always_comb begin
    state_d    = state_q;
    ret_d      = ret_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_WAIT: if (zero_i) state_d = ST_NOP;
      ST_NOP:  state_d = ST_PRE1;
      ST_GAP:  if (zero_i) state_d = ret_q;
      ST_DONE: ;
      default: begin
        if (space <= 1) begin
          state_d = follow;
        end else begin
          state_d    = ST_GAP;
          ret_d      = follow;
          load_o     = 1'b1;
          load_val_o = CNT_W'(space - 2);
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      ret_q   <= ST_WAIT;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      if (state_q == ST_REF) ref_q <= ref_q + 1'b1;
    end
  end

  assign step_o = state_q;

endmodule

// File: rtl/ddr_init_enc.sv
module ddr_init_enc
  import ddr_init_pkg::*;
#(
  parameter int A_W      = 12,
  parameter int AP_BIT   = 8,
  parameter int DLLR_BIT = 8
) (
  input  step_e          step_i,
  input  logic [2:0]     cas_lat_i,
  input  logic           burst_type_i,
  input  logic [2:0]     burst_len_i,
  output ctl_t           ctl_o,
  output logic [1:0]     ba_o,
  output logic [A_W-1:0] addr_o,
  output logic           done_o
);

  logic [A_W-1:0] mode;

  always_comb begin
    mode      = '0;
    mode[2:0] = burst_len_i;
    mode[3]   = burst_type_i;
    mode[6:4] = cas_lat_i;
  end

  always_comb begin
    ctl_o  = CTL_NOP;
    ba_o   = 2'b00;
    addr_o = '0;
    unique case (step_i)
      ST_WAIT:          ctl_o.cke = 1'b0;
      ST_PRE1, ST_PRE2: begin ctl_o = CTL_PRE; addr_o[AP_BIT] = 1'b1; end
      ST_EMRS:          begin ctl_o = CTL_MRS; ba_o = 2'b01; end
      ST_MRS_RST:       begin ctl_o = CTL_MRS; addr_o = mode; addr_o[DLLR_BIT] = 1'b1; end
      ST_REF:           ctl_o = CTL_REF;
      ST_MRS_FIN:       begin ctl_o = CTL_MRS; addr_o = mode; end
      default:          ;
    endcase
  end

  assign done_o = (step_i == ST_DONE);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int A_W      = 12,
  parameter int AP_BIT   = 8,
  parameter int DLLR_BIT = 8,
  parameter int T_STABLE = 10000,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 8,
  parameter int T_LOCK   = 200,
  parameter int N_REF    = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2:0]     cas_lat_i,
  input  logic           burst_type_i,
  input  logic [2:0]     burst_len_i,
  output logic           cke_o,
  output logic           cs_n_o,
  output logic           ras_n_o,
  output logic           cas_n_o,
  output logic           we_n_o,
  output logic [1:0]     ba_o,
  output logic [A_W-1:0] addr_o,
  output logic           done_o
);

  localparam int MAX_CNT = max2(max2(T_STABLE, T_LOCK + 1), max2(T_RFC, max2(T_RP, T_MRD)));
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             zero;
  step_e            step;
  ctl_t             ctl;

  ddr_init_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(CNT_W'(T_STABLE - 1))
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .zero_o    (zero)
  );

  ddr_init_fsm #(
    .CNT_W (CNT_W),
    .T_RP  (T_RP),
    .T_MRD (T_MRD),
    .T_RFC (T_RFC),
    .T_LOCK(T_LOCK),
    .N_REF (N_REF)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .zero_i    (zero),
    .load_o    (load),
    .load_val_o(load_val),
    .step_o    (step)
  );

  ddr_init_enc #(
    .A_W     (A_W),
    .AP_BIT  (AP_BIT),
    .DLLR_BIT(DLLR_BIT)
  ) u_enc (
    .step_i      (step),
    .cas_lat_i   (cas_lat_i),
    .burst_type_i(burst_type_i),
    .burst_len_i (burst_len_i),
    .ctl_o       (ctl),
    .ba_o        (ba_o),
    .addr_o      (addr_o),
    .done_o      (done_o)
  );

  assign cke_o   = ctl.cke;
  assign cs_n_o  = ctl.cs_n;
  assign ras_n_o = ctl.ras_n;
  assign cas_n_o = ctl.cas_n;
  assign we_n_o  = ctl.we_n;

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
  parameter int A_W    = 12,
  parameter int AP_BIT = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cke_o,
  input logic           cs_n_o,
  input logic           ras_n_o,
  input logic           cas_n_o,
  input logic           we_n_o,
  input logic [1:0]     ba_o,
  input logic [A_W-1:0] addr_o,
  input logic           done_o
);

  logic is_nop, is_pre, is_mrs;
  assign is_nop = !cs_n_o && ras_n_o && cas_n_o && we_n_o;
  assign is_pre = !cs_n_o && !ras_n_o && cas_n_o && !we_n_o;
  assign is_mrs = !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;

  p_wait_is_nop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> is_nop);

  p_pre_all_banks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> addr_o[AP_BIT]);

  p_mode_load_spaced_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |=> is_nop);

  p_mode_bank_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |-> !ba_o[1]);

  p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cke_o && is_nop));

  p_cke_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

endmodule

bind ddr_init_seq ddr_init_chk #(.A_W(A_W), .AP_BIT(AP_BIT)) u_chk (.*);

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;

  localparam int TS    = 20;
  localparam int TRP   = 3;
  localparam int TMRD  = 2;
  localparam int TRFC  = 7;
  localparam int TLOCK = 16;
  localparam int NREF  = 2;
  localparam int AW    = 12;

  // kinds: 0 nop(cke up) 1 pre 2 emrs 3 mrs dll-reset 4 refresh 5 mrs final
  localparam int N_EV = 8;
  localparam int C_NOP  = TS;
  localparam int C_PRE1 = C_NOP + 1;
  localparam int C_EMRS = C_PRE1 + TRP;
  localparam int C_MRS1 = C_EMRS + TMRD;
  localparam int C_PRE2 = C_MRS1 + TLOCK + 1;
  localparam int C_REF0 = C_PRE2 + TRP;
  localparam int C_REF1 = C_REF0 + TRFC;
  localparam int C_MRS2 = C_REF1 + TRFC;
  localparam int C_DONE = C_MRS2 + TMRD;
  localparam int EV_CYC [N_EV] = '{C_NOP, C_PRE1, C_EMRS, C_MRS1, C_PRE2, C_REF0, C_REF1, C_MRS2};
  localparam int EV_KIND[N_EV] = '{0, 1, 2, 3, 1, 4, 4, 5};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] cas_lat;
  logic       burst_type;
  logic [2:0] burst_len;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0]    ba;
  logic [AW-1:0] addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ddr_init_seq #(
    .A_W(AW), .T_STABLE(TS), .T_RP(TRP), .T_MRD(TMRD),
    .T_RFC(TRFC), .T_LOCK(TLOCK), .N_REF(NREF)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cas_lat_i(cas_lat), .burst_type_i(burst_type),
    .burst_len_i(burst_len), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .done_o(done)
  );

  task automatic check(string req, int k, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual 0x%0h expected 0x%0h", req, k, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mode_word(logic dll, logic [2:0] cl, logic bt, logic [2:0] bl);
    logic [AW-1:0] m = '0;
    m[8] = dll; m[6:4] = cl; m[3] = bt; m[2:0] = bl;
    return m;
  endfunction

  // walk cycles 0..last after release, one sample per cycle at the falling edge
  task automatic run_seq(logic [2:0] cl, logic bt, logic [2:0] bl, int last);
    cas_lat = cl; burst_type = bt; burst_len = bl;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k <= last; k++) begin
      int  kind = -1;
      string tag;
      logic [3:0] code;
      if (k > 0) @(negedge clk);
      #1;
      if (k == C_DONE + 2) begin
        cas_lat = ~cl; burst_type = ~bt; burst_len = ~bl;
        #1;
      end
      for (int j = 0; j < N_EV; j++) if (EV_CYC[j] == k) kind = EV_KIND[j];
      code = {cs_n, ras_n, cas_n, we_n};
      tag  = (k < TS) ? "R1" : (k >= C_DONE) ? "R8" : "R9";
      check((k < TS) ? "R1" : "R10", k, {31'd0, cke}, {31'd0, k >= TS});
      check("R8", k, {31'd0, done}, {31'd0, k >= C_DONE});
      case (kind)
        0: check("R2", k, {28'd0, code}, 32'h7);
        1: begin
          check((k == C_PRE1) ? "R2" : "R5", k, {28'd0, code}, 32'h2);
          check((k == C_PRE1) ? "R2" : "R5", k, {20'd0, addr}, 32'h100);
        end
        2: begin
          check("R3", k, {28'd0, code}, 32'h0);
          check("R3", k, {18'd0, ba, addr}, 32'h1000);
        end
        3: begin
          check("R4", k, {28'd0, code}, 32'h0);
          check("R4", k, {18'd0, ba, addr}, {20'd0, mode_word(1'b1, cl, bt, bl)});
        end
        4: check("R6", k, {28'd0, code}, 32'h1);
        5: begin
          check("R7", k, {28'd0, code}, 32'h0);
          check("R7", k, {18'd0, ba, addr}, {20'd0, mode_word(1'b0, cl, bt, bl)});
        end
        default: check(tag, k, {28'd0, code}, 32'h7);
      endcase
    end
  endtask

  initial begin
    cas_lat = 3'b011; burst_type = 1'b0; burst_len = 3'b010;
    #1;
    check("R1", 0, {31'd0, cke}, 32'd0);
    check("R8", 0, {31'd0, done}, 32'd0);
    #40;

    // CL 3, sequential, BL 4
    run_seq(3'b011, 1'b0, 3'b010, C_DONE + 12);

    // R11: reset after done
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R11", -1, {30'd0, cke, done}, 32'd0);

    // CL 4, interleaved, BL 8, cut off inside the lock window
    run_seq(3'b100, 1'b1, 3'b011, C_MRS1 + 5);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R11", -1, {30'd0, cke, done}, 32'd0);
    check("R11", -1, {28'd0, cs_n, ras_n, cas_n, we_n}, 32'h7);

    // restart from scratch: CL 4, interleaved, BL 2
    run_seq(3'b100, 1'b1, 3'b001, C_DONE + 6);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule